// File: doc/BRIEF.md
# Signed/Unsigned Sequential Long Divider

This block divides a double-width dividend (32 bits by default) by a single-width divisor (16 bits by default). It works either on unsigned numbers or on two's-complement numbers, chosen per operation by a mode input. The answer comes back as one packed word: the low half holds the quotient and the high half holds the remainder. The block also produces a five-bit condition-flag vector, plus one-cycle pulses that mark a zero divisor or a quotient that does not fit.

A caller raises `start` for one cycle with the operands, the mode and an incoming extend flag. While the operation runs, `busy` stays high. `done` pulses once when the outputs are valid.

Two cases are caught before any iteration: a zero divisor, and a quotient that is certain to be too large. Both finish in a few cycles. Any other operation runs a restoring shift-subtract loop that yields one quotient bit per clock. A range check on the signed quotient follows the loop.

Top module: `quo_rem_divider`

## Requirements
- R1: In unsigned mode (`signed_mode`=0) with no exception, `result[15:0]` is the quotient and `result[31:16]` the remainder of `dividend / divisor`.
- R2: In signed mode (`signed_mode`=1) both operands are two's complement and the quotient is truncated toward zero.
- R3: In signed mode a nonzero remainder carries the sign of the dividend.
- R4: A zero divisor makes `div_zero` pulse together with `done`, and leaves `result` and `flags` at their previous values.
- R5: In unsigned mode, when `dividend[31:16]` is greater than or equal to the divisor, the operation ends early. `overflow` pulses, flag V is set and `result` equals the original dividend.
- R6: In signed mode, a quotient outside -32768..32767 gives the same overflow outcome as R5. It is found early when the upper half of the dividend magnitude is greater than or equal to the divisor magnitude, and otherwise after the loop.
- R7: `flags` is {X,N,Z,V,C} at bits 4..0. X is the `x_in` value captured at start and C is always 0. After a completed division, N is quotient bit 15, Z is set when the 16-bit quotient is zero, and V is 0.
- R8: Let the edge that accepts `start` be E0. `busy` is high after E0. `done` is high for exactly one cycle, with `busy` low, after edge E0+1 for a zero divisor or an early overflow, and after edge E0+18 otherwise.
- R9: A `start` presented while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `div_zero`, `overflow`, `result` and `flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division |
| signed_mode | input | 1 | 1 = two's complement, 0 = unsigned |
| dividend | input | 32 | Dividend |
| divisor | input | 16 | Divisor |
| x_in | input | 1 | Extend flag carried through to `flags[4]` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | {remainder, quotient}, or the dividend on overflow |
| flags | output | 5 | {X,N,Z,V,C} |
| div_zero | output | 1 | Zero-divisor pulse, coincident with `done` |
| overflow | output | 1 | Overflow pulse, coincident with `done` |

## Verification
The assertions assume that operands are captured only when the block is idle and then stay fixed for the whole operation. They also assume that the early check guarantees a partial remainder below the divisor magnitude before the first step. The bench drives `start` only at negative clock edges and holds it for one cycle. It deliberately repeats `start` while `busy` is high to confirm that the captured operands survive. The operand mix covers the sign combinations, the most negative dividend, a quotient of exactly -32768 and +32768, a zero divisor, and random values. Each case is compared cycle by cycle against a behavioural model that uses integer division.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CHK  = 2'd1,
        ST_RUN  = 2'd2,
        ST_FIN  = 2'd3
    } dstate_t;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    function automatic ccr_t make_ovf_flags(input logic x);
        ccr_t f;
        f.x = x;
        f.n = 1'b0;
        f.z = 1'b0;
        f.v = 1'b1;
        f.c = 1'b0;
        return f;
    endfunction
endpackage

// File: rtl/div_prep.sv
module div_prep #(
    parameter int W = 16
) (
    input  logic [2*W-1:0] dvd,
    input  logic [W-1:0]   dvs,
    input  logic           sgn,
    output logic [2*W-1:0] mag_a,
    output logic [W-1:0]   mag_b,
    output logic           neg_q,
    output logic           neg_r,
    output logic           zero,
    output logic           early_ovf
);
    logic a_neg, b_neg;

    always_comb begin
        a_neg     = sgn & dvd[2*W-1];
        b_neg     = sgn & dvs[W-1];
        mag_a     = a_neg ? (~dvd + 1'b1) : dvd;
        mag_b     = b_neg ? (~dvs + 1'b1) : dvs;
        neg_q     = a_neg ^ b_neg;
        neg_r     = a_neg;
        zero      = (dvs == '0);
        early_ovf = !zero && (mag_a[2*W-1:W] >= mag_b);
    end
endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [2*W-1:0] mag_a,
    input  logic [W-1:0]   mag_b,
    output logic [W-1:0]   quo,
    output logic [W-1:0]   rem,
    output logic           last
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  rem_q, quo_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    trial;
    logic          fits;

    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        fits  = trial >= {1'b0, mag_b};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            rem_q <= mag_a[2*W-1:W];
            quo_q <= mag_a[W-1:0];
            cnt_q <= '0;
        end else if (step) begin
            rem_q <= fits ? W'(trial - {1'b0, mag_b}) : trial[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign quo  = quo_q;
    assign rem  = rem_q;
    assign last = (cnt_q == CW'(W - 1));

    // R1
    rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
        step |=> (rem_q < mag_b));
endmodule

// File: rtl/div_post.sv
module div_post #(
    parameter int W = 16
) (
    input  logic         sgn,
    input  logic         neg_q,
    input  logic         neg_r,
    input  logic [W-1:0] quo,
    input  logic [W-1:0] rem,
    output logic [W-1:0] q_out,
    output logic [W-1:0] r_out,
    output logic         range_ovf
);
    localparam logic [W-1:0] HALF = W'(1) << (W - 1);

    always_comb begin
        q_out     = neg_q ? (~quo + 1'b1) : quo;
        r_out     = neg_r ? (~rem + 1'b1) : rem;
        range_ovf = sgn && (neg_q ? (quo > HALF) : (quo >= HALF));
    end
endmodule

// File: rtl/quo_rem_divider.sv
module quo_rem_divider #(
    parameter int DVS_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 signed_mode,
    input  logic [2*DVS_W-1:0]   dividend,
    input  logic [DVS_W-1:0]     divisor,
    input  logic                 x_in,
    output logic                 busy,
    output logic                 done,
    output logic [2*DVS_W-1:0]   result,
    output logic [4:0]           flags,
    output logic                 div_zero,
    output logic                 overflow
);
    import div_pkg::*;
    localparam int W  = DVS_W;
    localparam int DW = 2 * DVS_W;

    dstate_t        state;
    logic [DW-1:0]  dvd_l;
    logic [W-1:0]   dvs_l;
    logic           sgn_l, x_l;
    logic [DW-1:0]  result_q;
    ccr_t           flags_q;
    logic           done_q, dz_q, ovf_q;

    logic [DW-1:0]  mag_a;
    logic [W-1:0]   mag_b, quo, rem, q_out, r_out;
    logic           neg_q, neg_r, zero, early_ovf, last, range_ovf;
    logic           load, step;

    div_prep #(.W(W)) u_prep (
        .dvd(dvd_l), .dvs(dvs_l), .sgn(sgn_l),
        .mag_a(mag_a), .mag_b(mag_b), .neg_q(neg_q), .neg_r(neg_r),
        .zero(zero), .early_ovf(early_ovf)
    );

    assign load = (state == ST_CHK) && !zero && !early_ovf;
    assign step = (state == ST_RUN);

    div_step #(.W(W)) u_step (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .mag_a(mag_a), .mag_b(mag_b), .quo(quo), .rem(rem), .last(last)
    );

    div_post #(.W(W)) u_post (
        .sgn(sgn_l), .neg_q(neg_q), .neg_r(neg_r), .quo(quo), .rem(rem),
        .q_out(q_out), .r_out(r_out), .range_ovf(range_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            dvd_l    <= '0;
            dvs_l    <= '0;
            sgn_l    <= 1'b0;
            x_l      <= 1'b0;
            result_q <= '0;
            flags_q  <= '0;
            done_q   <= 1'b0;
            dz_q     <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            dz_q   <= 1'b0;
            ovf_q  <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    dvd_l <= dividend;
                    dvs_l <= divisor;
                    sgn_l <= signed_mode;
                    x_l   <= x_in;
                    state <= ST_CHK;
                end
                ST_CHK: begin
                    if (zero) begin
                        dz_q   <= 1'b1;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (early_ovf) begin
                        result_q <= dvd_l;
                        flags_q  <= make_ovf_flags(x_l);
                        ovf_q    <= 1'b1;
                        done_q   <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        state <= ST_RUN;
                    end
                end
                ST_RUN: if (last) state <= ST_FIN;
                ST_FIN: begin
                    if (range_ovf) begin
                        result_q <= dvd_l;
                        flags_q  <= make_ovf_flags(x_l);
                        ovf_q    <= 1'b1;
                    end else begin
                        result_q  <= {r_out, q_out};
                        flags_q.x <= x_l;
                        flags_q.n <= q_out[W-1];
                        flags_q.z <= (q_out == '0);
                        flags_q.v <= 1'b0;
                        flags_q.c <= 1'b0;
                    end
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign result   = result_q;
    assign flags    = flags_q;
    assign div_zero = dz_q;
    assign overflow = ovf_q;

    // R8
    done_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8
    done_while_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R4
    dz_keeps_result: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> ($stable(result) && $stable(flags)));
    // R5
    ovf_keeps_operand: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (flags[1] && result == dvd_l));
    // R9
    start_ignored_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(dvd_l) && $stable(dvs_l) && $stable(sgn_l)));
    // R1
    unsigned_identity: assert property (@(posedge clk) disable iff (rst)
        (done && !div_zero && !overflow && !sgn_l) |->
        (DW'(result[W-1:0]) * DW'(dvs_l) + DW'(result[DW-1:W]) == dvd_l));
    // R3
    rem_sign_follows: assert property (@(posedge clk) disable iff (rst)
        (done && !div_zero && !overflow && sgn_l && result[DW-1:W] != '0) |->
        (result[DW-1] == dvd_l[DW-1]));
endmodule

// File: tb/quo_rem_divider_test.sv
module quo_rem_divider_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        x_in = 1'b0;
    logic        busy, done, div_zero, overflow;
    logic [31:0] result;
    logic [4:0]  flags;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [31:0] m_result = '0;
    logic [4:0]  m_flags = '0;

    quo_rem_divider uut (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor), .x_in(x_in),
        .busy(busy), .done(done), .result(result), .flags(flags),
        .div_zero(div_zero), .overflow(overflow)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [15:0] b, input bit sm,
                          input bit xi, input bit poke);
        longint av, bv, q, r, ma, mb;
        bit dz, ov, early;
        int lat;
        logic [31:0] exp_res;
        logic [4:0]  exp_fl;
        av = sm ? longint'($signed(a)) : longint'({32'b0, a});
        bv = sm ? longint'($signed(b)) : longint'({48'b0, b});
        dz = (b == 16'h0);
        q = 0; r = 0; ov = 0; early = 0;
        if (!dz) begin
            q  = av / bv;
            r  = av % bv;
            ov = sm ? (q < -32768 || q > 32767) : (q > 65535);
            ma = (av < 0) ? -av : av;
            mb = (bv < 0) ? -bv : bv;
            early = ((ma >> 16) >= mb);
        end
        lat = (dz || early) ? 1 : 18;
        exp_res = m_result;
        exp_fl  = m_flags;
        if (dz) begin
        end else if (ov) begin
            exp_res = a;
            exp_fl  = {xi, 2'b00, 1'b1, 1'b0};
        end else begin
            exp_res = {r[15:0], q[15:0]};
            exp_fl  = {xi, q[15], (q[15:0] == 16'h0), 1'b0, 1'b0};
        end
        start = 1'b1; dividend = a; divisor = b; signed_mode = sm; x_in = xi;
        @(posedge clk);
        @(negedge clk);
        if (poke) begin
            start = 1'b1; dividend = ~a; divisor = b ^ 16'h0101; signed_mode = ~sm; x_in = ~xi;
        end else begin
            start = 1'b0;
        end
        for (int j = 0; j <= lat + 1; j++) begin
            if (j > 0) begin
                @(negedge clk);
                start = 1'b0;
            end
            // R8 busy/done timing
            chk(busy == (j < lat), "R8 busy", 32'(busy), 32'(j < lat));
            chk(done == (j == lat), "R8 done", 32'(done), 32'(j == lat));
            if (j < lat) begin
                // R4/R9 outputs held while running
                chk(result == m_result, "R9 result held", result, m_result);
                chk(flags == m_flags, "R9 flags held", 32'(flags), 32'(m_flags));
            end else if (j == lat) begin
                chk(div_zero == dz, "R4 div_zero", 32'(div_zero), 32'(dz));
                chk(overflow == ov, sm ? "R6 overflow" : "R5 overflow", 32'(overflow), 32'(ov));
                chk(result == exp_res, sm ? "R2 R3 R6 result" : "R1 R5 result", result, exp_res);
                if (ov)
                    chk({flags[4], flags[1:0]} == {exp_fl[4], exp_fl[1:0]}, "R7 flags ovf",
                        32'(flags), 32'(exp_fl));
                else
                    chk(flags == exp_fl, "R7 flags", 32'(flags), 32'(exp_fl));
                m_result = exp_res;
                m_flags  = flags;
                if (!ov) m_flags = exp_fl;
            end else begin
                chk(!div_zero && !overflow, "R8 pulses end", {div_zero, overflow}, 32'h0);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk(!busy && !done && !div_zero && !overflow, "R10 controls", {busy, done, div_zero, overflow}, 32'h0);
        chk(result == 32'h0 && flags == 5'h0, "R10 outputs", result, 32'h0);

        run_op(32'd100000, 16'd7, 1'b0, 1'b1, 1'b0);      // R1
        run_op(32'd5, 16'd9, 1'b0, 1'b0, 1'b0);           // R7 Z
        run_op(32'hFFFEFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0); // R1 max quotient
        run_op(32'h00070000, 16'd7, 1'b0, 1'b1, 1'b0);    // R5 equal boundary
        run_op(32'h00123456, 16'd0, 1'b0, 1'b0, 1'b0);    // R4
        run_op(32'hFFFFFFF9, 16'd2, 1'b1, 1'b0, 1'b0);    // R2 R3 -7/2
        run_op(32'd7, 16'hFFFE, 1'b1, 1'b1, 1'b0);        // R2 7/-2
        run_op(32'hFFFFFFF9, 16'hFFFE, 1'b1, 1'b0, 1'b0); // R3 -7/-2
        run_op(32'h00008000, 16'd1, 1'b1, 1'b0, 1'b0);    // R6 late overflow
        run_op(32'hFFFF8000, 16'd1, 1'b1, 1'b1, 1'b0);    // R6 -32768 fits
        run_op(32'hFFFF0000, 16'd2, 1'b1, 1'b0, 1'b0);    // R6 -32768 via loop
        run_op(32'h80000000, 16'hFFFF, 1'b1, 1'b0, 1'b0); // R6 early
        run_op(32'hFFFFFF00, 16'd0, 1'b1, 1'b1, 1'b0);    // R4 signed
        run_op(32'd123456, 16'd321, 1'b0, 1'b0, 1'b1);    // R9 start while busy
        run_op(32'h00090000, 16'd3, 1'b0, 1'b1, 1'b1);    // R9 short path
        for (int k = 0; k < 60; k++) begin
            logic [31:0] ra;
            logic [15:0] rb;
            ra = $urandom;
            rb = 16'($urandom);
            if (k % 3 == 0) ra = {16'($urandom % 32'(rb + 1)), 16'($urandom)};
            run_op(ra, rb, k[0], k[1], k[2] & k[3]);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule